// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 SDRAM interface and takes the memory from a cold start to a usable state. After its synchronous reset is released, it keeps the clock-enable pin low and the command bus deselected while power and clock settle. It then raises clock enable and plays out a fixed chain of commands: precharge-all, the three extended mode-register writes, and a mode-register write that resets the DLL. These are followed by a second precharge-all, a run of auto-refreshes and the operating mode-register write. The chain ends with the two extended mode-register writes that enter and then leave the default output-driver calibration state.

Every wait is counted in clock cycles. The settle time and the post-clock-enable wait are given in nanoseconds and converted with the clock period, rounding up. The precharge, refresh and mode-write gaps are given directly in cycles. The mode-register payload is assembled from burst length, CAS latency and write recovery. Two payloads are taken verbatim from parameters: the ones for extended registers 2 and 3. The extended register 1 payload comes from a parameter, with its DLL-enable and calibration fields forced by the sequencer. A ready flag rises once the last command's gap has elapsed. Normal traffic may start from that cycle.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset is released, `cke` stays low and the bus is deselected (`cs_n`=1) for exactly the settle-cycle count. From then on `cke` stays high. `odt` is low at all times.
- R2: The first command is precharge-all. It is issued exactly the post-clock-enable cycle count after `cke` rises. Precharge-all is encoded as {cs_n,ras_n,cas_n,we_n}=0010 with `addr[10]`=1 and `ba`=0. Every cycle between commands carries NOP (0111) once `cke` is high.
- R3: Commands come in this order: precharge-all, extended write 2 (`ba`=2), extended write 3 (`ba`=3), extended write 1 with DLL enabled (`ba`=1, `addr[0]`=0, `addr[9:7]`=000), mode write with DLL reset (`ba`=0, `addr[8]`=1), precharge-all, REFRESH_CNT auto-refreshes (0001), mode write with `addr[8]`=0, extended write 1 with `addr[9:7]`=111, then extended write 1 with `addr[9:7]`=000. A mode write is encoded 0000.
- R4: The gap to the next command is exactly TRP_CYC cycles after a precharge, TRFC_CYC after a refresh and TMRD_CYC after a mode write. The one exception is the calibration-entry write, which R5 may delay.
- R5: The calibration-entry write is issued no earlier than OCD_GAP_CYC cycles after the DLL-reset mode write. It is issued at whichever is later: that bound or the normal TMRD_CYC gap.
- R6: In both mode writes, `addr[2:0]` is 011 for burst length 8 and 010 for burst length 4. The other fields are `addr[6:4]`=CAS_LAT, `addr[11:9]`=WR_REC-1, and `addr[3]`, `addr[7]` and `addr[12]` are 0. `addr[15:13]` is 0 on every mode write.
- R7: Extended writes 2 and 3 carry EMR2_WORD and EMR3_WORD on `addr[12:0]`. Extended write 1 carries EMR1_BASE with bits 0, 7, 8 and 9 replaced by the sequencer.
- R8: `init_done` stays low until TMRD_CYC cycles after the calibration-exit write. It then stays high, with NOP on the bus, until reset.
- R9: While `rst` is high, in the same cycle, `cs_n`=1, `cke`=0 and `init_done`=0. Releasing `rst` restarts the whole chain from the settle phase.
- R10: A nanosecond wait becomes ceil(ns*1000/CLK_PS) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | output | 1 | Memory clock enable |
| odt | output | 1 | On-die termination enable, held low |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 3 | Bank address |
| addr | output | 16 | Address bus |
| init_done | output | 1 | Memory ready for normal traffic |

## Verification
The bench targets both outcomes of the calibration-window race. In one configuration the DLL-reset bound comes later than the normal mode-write gap; in the other the ordinary gap wins. A sequencer that ignores the bound would issue calibration entry too early. One that always waits the full bound would be late in the second case. A post-clock-enable wait of a fractional cycle count is used, so a truncating conversion shows up as precharge-all one cycle early. Resets are driven at random points mid-chain and after the ready flag. A design that registered its reset gating, or resumed rather than restarted, would show a command, a high `cke` or a stale ready flag in the reset cycle, or a shortened settle phase afterwards. Mode-register payloads with stray bits in the forced fields check that the DLL-enable and calibration bits are overwritten rather than merged.

// File: rtl/ddr2_init_pkg.sv
`timescale 1ns/1ps
package ddr2_init_pkg;

  typedef enum logic [3:0] {
    ST_STAB, ST_CKE, ST_PREA1, ST_EMR2, ST_EMR3, ST_EMR1, ST_MR_DLL,
    ST_PREA2, ST_REF, ST_MR_OP, ST_OCD_DEF, ST_OCD_EXIT, ST_DONE
  } step_t;

  typedef enum logic [1:0] {K_MODE, K_REF, K_PRE, K_NOP} kind_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam pins_t PINS_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam logic [12:0] PREA_WORD = 13'h0400;   // A10 high selects all banks
  localparam logic [12:0] EMR1_FORCED = 13'h0381; // DLL enable bit and calibration field

  function automatic pins_t kind_pins(kind_t k);
    case (k)
      K_MODE:  return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      K_REF:   return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      K_PRE:   return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      default: return '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
  endfunction

  // Nanoseconds to clock cycles, rounding up, at least one cycle.
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ps);
    int unsigned c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [12:0] mr_word(int unsigned bl, int unsigned cl,
                                          int unsigned wr, logic dll_rst);
    logic [12:0] w;
    w       = '0;
    w[2:0]  = (bl == 8) ? 3'd3 : 3'd2;
    w[6:4]  = 3'(cl);
    w[8]    = dll_rst;
    w[11:9] = 3'(wr - 1);
    return w;
  endfunction

  function automatic logic [12:0] emr1_word(logic [12:0] base, logic [2:0] ocd);
    logic [12:0] w;
    w      = base & ~EMR1_FORCED;
    w[9:7] = ocd;
    return w;
  endfunction

endpackage

// File: rtl/ddr2_init_timer.sv
`timescale 1ns/1ps
module ddr2_init_timer #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= W'(RST_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/ddr2_init_window.sv
`timescale 1ns/1ps
module ddr2_init_window #(
  parameter int unsigned SPAN = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic open_now
);
  localparam int unsigned W = $clog2(SPAN + 1);
  logic [W-1:0] cnt;
  logic         armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (start) begin
      cnt   <= W'(SPAN - 1);
      armed <= 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  assign open_now = armed && (cnt == '0);
endmodule

// File: rtl/ddr2_init_seq.sv
`timescale 1ns/1ps
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int unsigned CLK_PS      = 2500,
  parameter int unsigned STAB_NS     = 200000,
  parameter int unsigned CKE_WAIT_NS = 400,
  parameter int unsigned TRP_CYC     = 5,
  parameter int unsigned TRFC_CYC    = 51,
  parameter int unsigned TMRD_CYC    = 2,
  parameter int unsigned REFRESH_CNT = 2,
  parameter int unsigned OCD_GAP_CYC = 200,
  parameter int unsigned BURST_LEN   = 8,
  parameter int unsigned CAS_LAT     = 5,
  parameter int unsigned WR_REC      = 6,
  parameter logic [12:0] EMR1_BASE   = 13'h0004,
  parameter logic [12:0] EMR2_WORD   = 13'h0000,
  parameter logic [12:0] EMR3_WORD   = 13'h0000
) (
  input  logic        clk,
  input  logic        rst,
  output logic        cke,
  output logic        odt,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [2:0]  ba,
  output logic [15:0] addr,
  output logic        init_done
);
  localparam int unsigned STAB_CYC = ns_to_cyc(STAB_NS, CLK_PS);
  localparam int unsigned CKE_CYC  = ns_to_cyc(CKE_WAIT_NS, CLK_PS);
  localparam int unsigned MAX_CYC  = max_u(max_u(STAB_CYC, CKE_CYC),
                                           max_u(max_u(TRP_CYC, TRFC_CYC), TMRD_CYC));
  localparam int unsigned TW = $clog2(MAX_CYC + 1);
  localparam int unsigned RW = $clog2(REFRESH_CNT + 1);

  step_t       state, nxt;
  kind_t       kind;
  logic [2:0]  bank;
  logic [12:0] word;
  logic [TW-1:0] gap;
  logic        is_cmd, is_wait;
  logic [RW-1:0] refs_left;

  // Named internal events, observed by the checker.
  logic        wait_zero;
  logic        ocd_window_open;
  logic        cmd_fire;
  logic        dll_reset_fire;
  logic        advance;

  always_comb begin
    kind    = K_NOP;
    bank    = '0;
    word    = '0;
    gap     = TW'(TMRD_CYC);
    nxt     = state;
    is_cmd  = 1'b0;
    is_wait = 1'b0;
    case (state)
      ST_STAB:     begin is_wait = 1'b1; gap = TW'(CKE_CYC); nxt = ST_CKE; end
      ST_CKE:      begin is_wait = 1'b1; gap = TW'(1); nxt = ST_PREA1; end
      ST_PREA1:    begin is_cmd = 1'b1; kind = K_PRE; word = PREA_WORD;
                         gap = TW'(TRP_CYC); nxt = ST_EMR2; end
      ST_EMR2:     begin is_cmd = 1'b1; kind = K_MODE; bank = 3'd2;
                         word = EMR2_WORD; nxt = ST_EMR3; end
      ST_EMR3:     begin is_cmd = 1'b1; kind = K_MODE; bank = 3'd3;
                         word = EMR3_WORD; nxt = ST_EMR1; end
      ST_EMR1:     begin is_cmd = 1'b1; kind = K_MODE; bank = 3'd1;
                         word = emr1_word(EMR1_BASE, 3'b000); nxt = ST_MR_DLL; end
      ST_MR_DLL:   begin is_cmd = 1'b1; kind = K_MODE;
                         word = mr_word(BURST_LEN, CAS_LAT, WR_REC, 1'b1); nxt = ST_PREA2; end
      ST_PREA2:    begin is_cmd = 1'b1; kind = K_PRE; word = PREA_WORD;
                         gap = TW'(TRP_CYC); nxt = ST_REF; end
      ST_REF:      begin is_cmd = 1'b1; kind = K_REF; gap = TW'(TRFC_CYC);
                         nxt = (refs_left == RW'(1)) ? ST_MR_OP : ST_REF; end
      ST_MR_OP:    begin is_cmd = 1'b1; kind = K_MODE;
                         word = mr_word(BURST_LEN, CAS_LAT, WR_REC, 1'b0); nxt = ST_OCD_DEF; end
      ST_OCD_DEF:  begin is_cmd = 1'b1; kind = K_MODE; bank = 3'd1;
                         word = emr1_word(EMR1_BASE, 3'b111); nxt = ST_OCD_EXIT; end
      ST_OCD_EXIT: begin is_cmd = 1'b1; kind = K_MODE; bank = 3'd1;
                         word = emr1_word(EMR1_BASE, 3'b000); nxt = ST_DONE; end
      default:     ;
    endcase
  end

  assign cmd_fire       = is_cmd && wait_zero && ((state != ST_OCD_DEF) || ocd_window_open);
  assign advance        = cmd_fire || (is_wait && wait_zero);
  assign dll_reset_fire = cmd_fire && (state == ST_MR_DLL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_STAB;
      refs_left <= RW'(REFRESH_CNT);
    end else begin
      if (advance) state <= nxt;
      if (cmd_fire && state == ST_REF) refs_left <= refs_left - RW'(1);
    end
  end

  ddr2_init_timer #(.W(TW), .RST_VAL(STAB_CYC - 1)) u_gap (
    .clk(clk), .rst(rst), .load(advance), .load_val(gap - TW'(1)), .zero(wait_zero)
  );

  ddr2_init_window #(.SPAN(OCD_GAP_CYC)) u_ocd (
    .clk(clk), .rst(rst), .start(dll_reset_fire), .open_now(ocd_window_open)
  );

  pins_t pins;
  always_comb begin
    if (rst || state == ST_STAB) pins = PINS_DESEL;
    else if (cmd_fire)           pins = kind_pins(kind);
    else                         pins = kind_pins(K_NOP);
  end

  assign cs_n      = pins.cs_n;
  assign ras_n     = pins.ras_n;
  assign cas_n     = pins.cas_n;
  assign we_n      = pins.we_n;
  assign cke       = !rst && (state != ST_STAB);
  assign odt       = 1'b0;
  assign ba        = (cmd_fire && !rst) ? bank : 3'd0;
  assign addr      = (cmd_fire && !rst) ? {3'b000, word} : 16'd0;
  assign init_done = !rst && (state == ST_DONE) && wait_zero;
endmodule

// File: rtl/ddr2_init_checker.sv
`timescale 1ns/1ps
module ddr2_init_checker #(
  parameter int unsigned TRP_CYC     = 5,
  parameter int unsigned TRFC_CYC    = 51,
  parameter int unsigned TMRD_CYC    = 2,
  parameter int unsigned OCD_GAP_CYC = 200
) (
  input logic        clk,
  input logic        rst,
  input logic        cke,
  input logic        odt,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [2:0]  ba,
  input logic [15:0] addr,
  input logic        init_done,
  input logic        cmd_fire,
  input logic        dll_reset_fire,
  input logic        ocd_window_open
);
  logic [3:0] code;
  logic       is_cmd, is_mode, is_ref, is_pre, is_ocd_entry, is_dll_rst;
  assign code         = {cs_n, ras_n, cas_n, we_n};
  assign is_mode      = (code == 4'b0000);
  assign is_ref       = (code == 4'b0001);
  assign is_pre       = (code == 4'b0010);
  assign is_cmd       = is_mode || is_ref || is_pre;
  assign is_ocd_entry = is_mode && (ba == 3'd1) && (addr[9:7] == 3'b111);
  assign is_dll_rst   = is_mode && (ba == 3'd0) && addr[8];

  logic [15:0] since_cmd;
  logic [1:0]  last_kind;  // 0 mode, 1 refresh, 2 precharge
  logic        seen_cmd;
  logic [15:0] since_dll;
  logic        seen_dll;
  int unsigned need;

  always_comb begin
    case (last_kind)
      2'd1:    need = TRFC_CYC;
      2'd2:    need = TRP_CYC;
      default: need = TMRD_CYC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      since_cmd <= '0;
      last_kind <= 2'd0;
      seen_cmd  <= 1'b0;
      since_dll <= '0;
      seen_dll  <= 1'b0;
    end else begin
      if (is_cmd) begin
        since_cmd <= 16'd1;
        seen_cmd  <= 1'b1;
        last_kind <= is_ref ? 2'd1 : (is_pre ? 2'd2 : 2'd0);
      end else if (since_cmd != 16'hFFFF) begin
        since_cmd <= since_cmd + 16'd1;
      end
      if (is_dll_rst) begin
        since_dll <= 16'd1;
        seen_dll  <= 1'b1;
      end else if (since_dll != 16'hFFFF) begin
        since_dll <= since_dll + 16'd1;
      end
    end
  end

  // R9: reset gating is immediate, not registered
  always @(posedge clk) begin
    if (rst) begin
      p_reset_bus_r9: assert (cs_n && !cke && !init_done)
        else $error("reset bus not quiet");
    end
  end

  // R1
  p_cke_stays_r1: assert property (@(posedge clk) disable iff (rst) cke |=> cke);
  p_deselect_cke_low_r1: assert property (@(posedge clk) disable iff (rst) !cke |-> cs_n);
  p_odt_low_r1: assert property (@(posedge clk) disable iff (rst) !odt);
  // R3
  p_fire_on_bus_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_fire |-> (is_cmd && cke));
  p_prea_all_r3: assert property (@(posedge clk) disable iff (rst) is_pre |-> addr[10]);
  // R4
  p_min_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (is_cmd && seen_cmd) |-> (32'(since_cmd) >= need));
  // R5
  p_ocd_after_dll_r5: assert property (@(posedge clk) disable iff (rst)
    is_ocd_entry |-> (seen_dll && 32'(since_dll) >= OCD_GAP_CYC));
  p_window_after_start_r5: assert property (@(posedge clk) disable iff (rst)
    dll_reset_fire |=> !ocd_window_open || (OCD_GAP_CYC == 1));
  // R6
  p_mode_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    is_mode |-> (addr[15:13] == 3'b000));
  // R8
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst) init_done |=> init_done);
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (code == 4'b0111));
endmodule

bind ddr2_init_seq ddr2_init_checker #(
  .TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC), .TMRD_CYC(TMRD_CYC), .OCD_GAP_CYC(OCD_GAP_CYC)
) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .odt(odt), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done),
  .cmd_fire(cmd_fire), .dll_reset_fire(dll_reset_fire), .ocd_window_open(ocd_window_open)
);

// File: tb/ddr2_init_seq_test.sv
`timescale 1ns/1ps
module ddr2_init_seq_test;
  localparam int CLK_PERIOD = 10;     // ns
  localparam int CLK_PS_V   = 10000;  // same period in ps, for the design

  // Two configurations: index 0 -> uut, index 1 -> uut4
  localparam int STAB_V[2]  = '{1000, 500};
  localparam int CKEW_V[2]  = '{405, 400};
  localparam int TRP_V[2]   = '{3, 4};
  localparam int TRFC_V[2]  = '{7, 9};
  localparam int TMRD_V[2]  = '{2, 3};
  localparam int REF_V[2]   = '{3, 2};
  localparam int OCD_V[2]   = '{60, 10};
  localparam int BL_V[2]    = '{8, 4};
  localparam int CL_V[2]    = '{4, 5};
  localparam int WR_V[2]    = '{3, 4};
  localparam int EMR1_V[2]  = '{'h0044, 'h0385};
  localparam int EMR2_V[2]  = '{'h0080, 'h0000};
  localparam int EMR3_V[2]  = '{'h0000, 'h0000};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic a_cke, a_odt, a_cs, a_ras, a_cas, a_we, a_done;
  logic [2:0] a_ba;
  logic [15:0] a_addr;
  logic b_cke, b_odt, b_cs, b_ras, b_cas, b_we, b_done;
  logic [2:0] b_ba;
  logic [15:0] b_addr;

  ddr2_init_seq #(
    .CLK_PS(CLK_PS_V), .STAB_NS(STAB_V[0]), .CKE_WAIT_NS(CKEW_V[0]),
    .TRP_CYC(TRP_V[0]), .TRFC_CYC(TRFC_V[0]), .TMRD_CYC(TMRD_V[0]),
    .REFRESH_CNT(REF_V[0]), .OCD_GAP_CYC(OCD_V[0]), .BURST_LEN(BL_V[0]),
    .CAS_LAT(CL_V[0]), .WR_REC(WR_V[0]), .EMR1_BASE(13'(EMR1_V[0])),
    .EMR2_WORD(13'(EMR2_V[0])), .EMR3_WORD(13'(EMR3_V[0]))
  ) uut (
    .clk(clk), .rst(rst), .cke(a_cke), .odt(a_odt), .cs_n(a_cs), .ras_n(a_ras),
    .cas_n(a_cas), .we_n(a_we), .ba(a_ba), .addr(a_addr), .init_done(a_done)
  );

  ddr2_init_seq #(
    .CLK_PS(CLK_PS_V), .STAB_NS(STAB_V[1]), .CKE_WAIT_NS(CKEW_V[1]),
    .TRP_CYC(TRP_V[1]), .TRFC_CYC(TRFC_V[1]), .TMRD_CYC(TMRD_V[1]),
    .REFRESH_CNT(REF_V[1]), .OCD_GAP_CYC(OCD_V[1]), .BURST_LEN(BL_V[1]),
    .CAS_LAT(CL_V[1]), .WR_REC(WR_V[1]), .EMR1_BASE(13'(EMR1_V[1])),
    .EMR2_WORD(13'(EMR2_V[1])), .EMR3_WORD(13'(EMR3_V[1]))
  ) uut4 (
    .clk(clk), .rst(rst), .cke(b_cke), .odt(b_odt), .cs_n(b_cs), .ras_n(b_ras),
    .cas_n(b_cas), .we_n(b_we), .ba(b_ba), .addr(b_addr), .init_done(b_done)
  );

  int sel = 0;
  logic m_cke, m_odt, m_done;
  logic [3:0] m_code;
  logic [2:0] m_ba;
  logic [15:0] m_addr;
  assign m_cke  = sel ? b_cke : a_cke;
  assign m_odt  = sel ? b_odt : a_odt;
  assign m_done = sel ? b_done : a_done;
  assign m_code = sel ? {b_cs, b_ras, b_cas, b_we} : {a_cs, a_ras, a_cas, a_we};
  assign m_ba   = sel ? b_ba : a_ba;
  assign m_addr = sel ? b_addr : a_addr;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
               req, what, act, act, exp, exp);
    end
  endtask

  // Bench-side restatement of the requirements
  function automatic int cyc_of(int ns);
    int q;
    q = (ns * 1000) / CLK_PS_V;
    if (q * CLK_PS_V < ns * 1000) q = q + 1;
    if (q < 1) q = 1;
    return q;
  endfunction

  function automatic int mr_exp(int bl, int cl, int wr, int dll);
    return ((bl == 8) ? 3 : 2) + cl * 16 + dll * 256 + (wr - 1) * 512;
  endfunction

  function automatic int emr1_exp(int base, int ocd);
    return (base - (base & 'h381)) + ocd * 128;
  endfunction

  localparam int C_MODE = 0, C_REF = 1, C_PRE = 2;

  int    e_cyc[32], e_code[32], e_ba[32], e_addr[32];
  string e_tag[32];
  int    e_n;
  int    c_cyc[32], c_code[32], c_ba[32], c_addr[32];
  int    c_n;

  task automatic push(input int cyc, input int code, input int bank,
                      input int a, input string tag);
    e_cyc[e_n] = cyc; e_code[e_n] = code; e_ba[e_n] = bank;
    e_addr[e_n] = a; e_tag[e_n] = tag;
    e_n++;
  endtask

  task automatic run_and_check(input int s);
    int stab, ckew, t, dll_t, done_exp, cyc, cke_rise, done_cyc;
    bit odt_seen, cke_drop, desel_bad;
    sel = s;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(m_code == 4'b1111 && !m_cke && !m_done, "R9", "reset state {cs,ras,cas,we,cke,done}",
        int'({m_code, m_cke, m_done}), 'b111100);
    @(negedge clk);
    rst = 1'b0;

    stab = cyc_of(STAB_V[s]);
    ckew = cyc_of(CKEW_V[s]);
    e_n = 0;
    t = stab + ckew;
    push(t, C_PRE, 0, 'h400, "R2");
    t += TRP_V[s];
    push(t, C_MODE, 2, EMR2_V[s], "R7");
    t += TMRD_V[s];
    push(t, C_MODE, 3, EMR3_V[s], "R7");
    t += TMRD_V[s];
    push(t, C_MODE, 1, emr1_exp(EMR1_V[s], 0), "R3");
    t += TMRD_V[s];
    dll_t = t;
    push(t, C_MODE, 0, mr_exp(BL_V[s], CL_V[s], WR_V[s], 1), "R6");
    t += TMRD_V[s];
    push(t, C_PRE, 0, 'h400, "R3");
    t += TRP_V[s];
    for (int r = 0; r < REF_V[s]; r++) begin
      push(t, C_REF, 0, 0, "R3");
      t += TRFC_V[s];
    end
    push(t, C_MODE, 0, mr_exp(BL_V[s], CL_V[s], WR_V[s], 0), "R6");
    t += TMRD_V[s];
    if (t < dll_t + OCD_V[s]) t = dll_t + OCD_V[s];
    push(t, C_MODE, 1, emr1_exp(EMR1_V[s], 7), "R5");
    t += TMRD_V[s];
    push(t, C_MODE, 1, emr1_exp(EMR1_V[s], 0), "R3");
    done_exp = t + TMRD_V[s];

    cyc = 0; c_n = 0; cke_rise = -1; done_cyc = -1;
    odt_seen = 0; cke_drop = 0; desel_bad = 0;
    while (cyc < 3000 && done_cyc < 0) begin
      #1;
      if (m_odt) odt_seen = 1;
      if (m_cke && cke_rise < 0) cke_rise = cyc;
      if (!m_cke && cke_rise >= 0) cke_drop = 1;
      if (!m_cke && m_code != 4'b1111) desel_bad = 1;
      if (m_cke && m_code != 4'b0111) begin
        if (c_n < 32) begin
          c_cyc[c_n] = cyc; c_code[c_n] = int'(m_code);
          c_ba[c_n] = int'(m_ba); c_addr[c_n] = int'(m_addr);
        end
        c_n++;
      end
      if (m_done) done_cyc = cyc;
      @(negedge clk);
      cyc++;
    end

    chk(cke_rise == stab, "R1", "cycle cke rises", cke_rise, stab);
    chk(cke_rise - stab == 0 && cyc_of(STAB_V[s]) == stab, "R10", "settle cycles rounded up",
        cke_rise, stab);
    chk(!odt_seen && !cke_drop && !desel_bad, "R1", "odt low, cke held, deselect while cke low",
        int'({odt_seen, cke_drop, desel_bad}), 0);
    chk(c_n == e_n, "R3", "command count", c_n, e_n);
    for (int i = 0; i < e_n && i < c_n; i++) begin
      chk(c_code[i] == e_code[i], "R3", $sformatf("cmd %0d code", i), c_code[i], e_code[i]);
      chk(c_ba[i] == e_ba[i] && c_addr[i] == e_addr[i], e_tag[i],
          $sformatf("cmd %0d bank*65536+addr", i),
          c_ba[i] * 65536 + c_addr[i], e_ba[i] * 65536 + e_addr[i]);
      chk(c_cyc[i] == e_cyc[i], (i == 0) ? "R2" : ((e_tag[i] == "R5") ? "R5" : "R4"),
          $sformatf("cmd %0d cycle", i), c_cyc[i], e_cyc[i]);
    end
    chk(c_cyc[0] - cke_rise == cyc_of(CKEW_V[s]), "R10", "clock-enable wait rounded up",
        c_cyc[0] - cke_rise, cyc_of(CKEW_V[s]));
    chk(done_cyc == done_exp, "R8", "init_done rise cycle", done_cyc, done_exp);
    for (int k = 0; k < 5; k++) begin
      #1;
      chk(m_done && m_code == 4'b0111, "R8", "done holds with NOP",
          int'({m_done, m_code}), 'b10111);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    repeat (2) @(negedge clk);
    run_and_check(0);
    run_and_check(1);
    // Reset after ready: outputs drop at once (R9)
    rst = 1'b1;
    #1;
    chk(!m_done && !m_cke && m_code == 4'b1111, "R9", "reset after done",
        int'({m_done, m_cke, m_code}), 'b001111);
    // Random mid-chain aborts followed by a complete restart (R9)
    for (int k = 0; k < 4; k++) begin
      int hold;
      sel = k % 2;
      @(negedge clk);
      rst = 1'b0;
      hold = int'($urandom_range(250, 5));
      repeat (hold) @(negedge clk);
      rst = 1'b1;
      #1;
      chk(m_code == 4'b1111 && !m_cke && !m_done, "R9",
          $sformatf("abort after %0d cycles", hold),
          int'({m_code, m_cke, m_done}), 'b111100);
      run_and_check(k % 2);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule